// File: doc/BRIEF.md
# Transmit Queue Command Controller

This block holds the host-side command logic of a single-port transmit frame queue. Software writes a 16-bit command word to hand the frame it has just prepared in the transmit buffer to the transmit engine, or to ask to be told when the buffer has enough free room for its next frames. Both command bits stay set while the matching frame is in flight. Both clear themselves when the transmit engine reports that the frame has finished.

A second register holds the number of bytes the host wants free. While the monitor command is armed, the block compares the free-space count from the buffer manager against that request. The first time the free space reaches the request, the block raises a memory-available interrupt. That interrupt is bit 6 of the interrupt status word, and it stays high until the host writes a 1 to that bit. The enqueue request reaches the transmit engine as a one-cycle strobe.

Top module: `txq_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_rdata` is all zero and `enq_strobe` and `mem_avail_irq` are low.
- R2: A command write with bit 0 = 1 while the enqueue bit is clear sets the enqueue bit. The bit reads back as 1 after that clock edge. `enq_strobe` is high for exactly the one cycle after that edge.
- R3: A command write with bit 0 = 1 while the enqueue bit is already set is ignored. The bit stays set and no strobe is issued.
- R4: A `frame_done` pulse clears the enqueue bit (bit 0) and the monitor bit (bit 1) at the next edge, whichever of them is set. In the same cycle, a write that sets a bit which was clear still takes effect.
- R5: A command write with bit 1 = 1 while the monitor bit is clear arms the monitor. If, at a clock edge, the monitor is armed and `free_space >= ` the requested size, `mem_avail_irq` goes high after that edge. Equality is enough.
- R6: While `free_space` is below the requested size, the armed monitor does not raise the interrupt.
- R7: `mem_avail_irq` stays high until a status write with bit 6 = 1. Status writes with bit 6 = 0 do not clear it. If a status write with bit 6 = 1 arrives in the same cycle as a new firing, the interrupt stays set.
- R8: Each arming of the monitor raises the interrupt at most once, even while the space condition still holds after the interrupt is cleared.
- R9: Command bits 15 to 2 always read as zero, and writing ones to them has no effect.
- R10: Writing 0 to a command bit has no effect; a set bit is cleared only by `frame_done`.
- R11: A write to the request-size register is used by the comparison from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word write data |
| req_wr | input | 1 | Request-size register write strobe |
| req_wdata | input | SPACE_W | Requested free space in bytes |
| stat_wr | input | 1 | Interrupt status write strobe (write 1 to clear) |
| stat_wdata | input | 16 | Interrupt status write data, bit 6 = memory available |
| free_space | input | SPACE_W | Current free bytes in the transmit buffer |
| frame_done | input | 1 | Transmit engine frame-finished pulse |
| enq_strobe | output | 1 | One-cycle enqueue request to the transmit engine |
| mem_avail_irq | output | 1 | Memory-available interrupt request |
| cmd_rdata | output | 16 | Command word read-back |

## Verification
The bench builds the block with `SPACE_W = 8`, so the 255-byte full-scale request, a zero request and equality at both ends of the range can be driven directly. At this width, full-scale free space can equal full-scale request, which is the edge of the comparator's `>=`. A zero request fires on the first armed cycle, and the bench uses this to hit the case where a firing and a status clear arrive in the same cycle. The one-shot rule is checked by holding the space above the request after the interrupt has been cleared.

// File: rtl/txq_cmd_pkg.sv
package txq_cmd_pkg;

    localparam int unsigned ENQ_BIT = 0;
    localparam int unsigned MON_BIT = 1;
    localparam int unsigned IRQ_BIT = 6;

    typedef struct packed {
        logic enq;
        logic mon;
        logic strobe;
    } cmd_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;

endpackage

// File: rtl/txq_cmd_bits.sv
module txq_cmd_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic set_enq,
    input  logic set_mon,
    input  logic frame_done,
    output logic enq_bit,
    output logic mon_bit,
    output logic enq_strobe
);
    import txq_cmd_pkg::*;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (st_q.enq) begin
            if (frame_done) st_d.enq = 1'b0;
        end else if (wr_en && set_enq) begin
            st_d.enq    = 1'b1;
            st_d.strobe = 1'b1;
        end
        if (st_q.mon) begin
            if (frame_done) st_d.mon = 1'b0;
        end else if (wr_en && set_mon) begin
            st_d.mon = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enq_bit    = st_q.enq;
    assign mon_bit    = st_q.mon;
    assign enq_strobe = st_q.strobe;

    // R2
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_strobe |=> !enq_strobe);
    // R2
    strobe_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_strobe |-> enq_bit);
    // R3
    enq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_bit && !frame_done) |=> (enq_bit && !enq_strobe));
    // R4
    enq_done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_bit && frame_done) |=> !enq_bit);
    // R4
    mon_done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_bit && frame_done) |=> !mon_bit);
    // R10
    enq_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_bit && !(wr_en && set_enq)) |=> !enq_bit);

endmodule

// File: rtl/txq_space_mon.sv
module txq_space_mon #(
    parameter int unsigned SPACE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_wr,
    input  logic [SPACE_W-1:0] req_wdata,
    input  logic [SPACE_W-1:0] free_space,
    input  logic               mon_bit,
    output logic               fire
);
    typedef struct packed {
        logic [SPACE_W-1:0] req;
        logic               fired;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       room_ok;

    always_comb begin
        room_ok = (free_space >= st_q.req);
        fire    = mon_bit && !st_q.fired && room_ok;
        st_d    = st_q;
        if (req_wr) st_d.req = req_wdata;
        if (!mon_bit)  st_d.fired = 1'b0;
        else if (fire) st_d.fired = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mon_bit) |=> !fire);
    // R11
    req_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> (st_q.req == $past(req_wdata)));

endmodule

// File: rtl/txq_irq_latch.sv
module txq_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_irq,
    input  logic clr_irq,
    output logic irq
);
    import txq_cmd_pkg::*;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_irq) st_d.irq = 1'b0;
        if (set_irq) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq);
    // R7
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_irq |=> irq);

endmodule

// File: rtl/txq_cmd_ctrl.sv
module txq_cmd_ctrl #(
    parameter int unsigned CMD_W   = 16,
    parameter int unsigned SPACE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_wdata,
    input  logic               req_wr,
    input  logic [SPACE_W-1:0] req_wdata,
    input  logic               stat_wr,
    input  logic [CMD_W-1:0]   stat_wdata,
    input  logic [SPACE_W-1:0] free_space,
    input  logic               frame_done,
    output logic               enq_strobe,
    output logic               mem_avail_irq,
    output logic [CMD_W-1:0]   cmd_rdata
);
    import txq_cmd_pkg::*;

    localparam int unsigned CTRL_BITS = 2;

    logic enq_bit, mon_bit, fire, clr_irq;

    assign clr_irq = stat_wr && stat_wdata[IRQ_BIT];

    txq_cmd_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cmd_wr),
        .set_enq    (cmd_wdata[ENQ_BIT]),
        .set_mon    (cmd_wdata[MON_BIT]),
        .frame_done (frame_done),
        .enq_bit    (enq_bit),
        .mon_bit    (mon_bit),
        .enq_strobe (enq_strobe)
    );

    txq_space_mon #(.SPACE_W(SPACE_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr     (req_wr),
        .req_wdata  (req_wdata),
        .free_space (free_space),
        .mon_bit    (mon_bit),
        .fire       (fire)
    );

    txq_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_irq (fire),
        .clr_irq (clr_irq),
        .irq     (mem_avail_irq)
    );

    // read-back: control bits at their positions, reserved bits tied low
    for (genvar b = 0; b < CMD_W; b++) begin : g_rd
        if (b == ENQ_BIT) begin : g_enq
            assign cmd_rdata[b] = enq_bit;
        end else if (b == MON_BIT) begin : g_mon
            assign cmd_rdata[b] = mon_bit;
        end else begin : g_rsvd
            assign cmd_rdata[b] = 1'b0;
        end
    end

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (cmd_wdata[CMD_W-1:CTRL_BITS] != '0)) |=> (cmd_rdata[CMD_W-1:CTRL_BITS] == '0));
    // R7
    other_stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && (stat_wdata != '0) && !stat_wdata[IRQ_BIT] && mem_avail_irq) |=> mem_avail_irq);
    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_avail_irq) |-> $past(mon_bit));
    // R6
    irq_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_avail_irq) |-> $past(fire));

endmodule

// File: tb/txq_cmd_ctrl_tb_top.sv
module txq_cmd_ctrl_tb_top;

    localparam int unsigned CMD_W   = 16;
    localparam int unsigned SPACE_W = 8;

    typedef struct {
        logic [CMD_W-1:0] rdata;
        logic             strobe;
        logic             irq;
        string            tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_wr = 1'b0;
    logic [CMD_W-1:0]   cmd_wdata = '0;
    logic               req_wr = 1'b0;
    logic [SPACE_W-1:0] req_wdata = '0;
    logic               stat_wr = 1'b0;
    logic [CMD_W-1:0]   stat_wdata = '0;
    logic [SPACE_W-1:0] free_space = '0;
    logic               frame_done = 1'b0;
    logic               enq_strobe, mem_avail_irq;
    logic [CMD_W-1:0]   cmd_rdata;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    txq_cmd_ctrl #(.CMD_W(CMD_W), .SPACE_W(SPACE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .req_wr(req_wr), .req_wdata(req_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .free_space(free_space), .frame_done(frame_done),
        .enq_strobe(enq_strobe), .mem_avail_irq(mem_avail_irq),
        .cmd_rdata(cmd_rdata)
    );

    // monitor: compares outputs 1 ns after each edge against the queued item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (cmd_rdata !== e.rdata || enq_strobe !== e.strobe || mem_avail_irq !== e.irq) begin
                    bad++;
                    $display("FAIL %s: got rdata=%h strobe=%b irq=%b, expected rdata=%h strobe=%b irq=%b",
                             e.tag, cmd_rdata, enq_strobe, mem_avail_irq, e.rdata, e.strobe, e.irq);
                end
            end
        end
    end

    // driver: sets one cycle of inputs and queues the outputs expected after the next edge
    task automatic cyc(input logic cw, input logic [CMD_W-1:0] cd,
                       input logic rw, input logic [SPACE_W-1:0] rd,
                       input logic sw, input logic [CMD_W-1:0] sd,
                       input logic [SPACE_W-1:0] fs, input logic fd,
                       input logic [CMD_W-1:0] er, input logic es, input logic ei,
                       input string tag);
        exp_t e;
        @(negedge clk);
        cmd_wr = cw; cmd_wdata = cd;
        req_wr = rw; req_wdata = rd;
        stat_wr = sw; stat_wdata = sd;
        free_space = fs; frame_done = fd;
        e.rdata = er; e.strobe = es; e.irq = ei; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        total++;
        if (cmd_rdata !== '0 || enq_strobe !== 1'b0 || mem_avail_irq !== 1'b0) begin
            bad++;
            $display("FAIL R1: got rdata=%h strobe=%b irq=%b, expected 0 0 0",
                     cmd_rdata, enq_strobe, mem_avail_irq);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //   cw   cd       rw  rd   sw  sd       fs   fd   rdata    st  irq
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 0,   0, 16'h0000, 0, 0, "R1 idle");
        cyc(1, 16'h0001, 0, 0,   0, 16'h0000, 0,   0, 16'h0001, 1, 0, "R2 enqueue set");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 0,   0, 16'h0001, 0, 0, "R2 strobe one cycle");
        cyc(1, 16'h0001, 0, 0,   0, 16'h0000, 0,   0, 16'h0001, 0, 0, "R3 rewrite ignored");
        cyc(1, 16'h0000, 0, 0,   0, 16'h0000, 0,   0, 16'h0001, 0, 0, "R10 zero write");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 0,   1, 16'h0000, 0, 0, "R4 done clears");
        cyc(1, 16'hFFFC, 0, 0,   0, 16'h0000, 0,   0, 16'h0000, 0, 0, "R9 reserved bits");
        cyc(0, 16'h0000, 1, 100, 0, 16'h0000, 50,  0, 16'h0000, 0, 0, "R11 load request");
        cyc(1, 16'h0002, 0, 0,   0, 16'h0000, 50,  0, 16'h0002, 0, 0, "R5 arm monitor");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 50,  0, 16'h0002, 0, 0, "R6 below request");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 99,  0, 16'h0002, 0, 0, "R6 one below");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 100, 0, 16'h0002, 0, 1, "R5 equal fires");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 200, 0, 16'h0002, 0, 1, "R7 holds");
        cyc(0, 16'h0000, 0, 0,   1, 16'h0020, 200, 0, 16'h0002, 0, 1, "R7 other bit no clear");
        cyc(0, 16'h0000, 0, 0,   1, 16'h0040, 200, 0, 16'h0002, 0, 0, "R7 bit6 clears");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 200, 0, 16'h0002, 0, 0, "R8 no refire");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 200, 1, 16'h0000, 0, 0, "R4 done clears mon");
        cyc(1, 16'h0003, 0, 0,   0, 16'h0000, 200, 0, 16'h0003, 1, 0, "R2 both bits");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 200, 0, 16'h0003, 0, 1, "R5 rearm fires");
        cyc(0, 16'h0000, 0, 0,   1, 16'h0040, 200, 1, 16'h0000, 0, 0, "R4 done with clear");
        cyc(0, 16'h0000, 1, 255, 0, 16'h0000, 10,  0, 16'h0000, 0, 0, "R11 full scale");
        cyc(1, 16'h0002, 0, 0,   0, 16'h0000, 254, 0, 16'h0002, 0, 0, "R11 arm");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 254, 0, 16'h0002, 0, 0, "R11 254 below 255");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 255, 0, 16'h0002, 0, 1, "R5 full scale equal");
        cyc(1, 16'h0001, 0, 0,   0, 16'h0000, 255, 1, 16'h0001, 1, 1, "R4 done plus new set");
        cyc(1, 16'h0001, 0, 0,   0, 16'h0000, 255, 1, 16'h0000, 0, 1, "R3 write during done");
        cyc(0, 16'h0000, 1, 0,   1, 16'h0040, 0,   0, 16'h0000, 0, 0, "R7 clear");
        cyc(1, 16'h0002, 0, 0,   0, 16'h0000, 0,   0, 16'h0002, 0, 0, "R5 arm zero request");
        cyc(0, 16'h0000, 0, 0,   1, 16'h0040, 0,   0, 16'h0002, 0, 1, "R7 set beats clear");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 0,   1, 16'h0000, 0, 1, "R7 kept past done");
        cyc(0, 16'h0000, 0, 0,   1, 16'h0040, 0,   0, 16'h0000, 0, 0, "R7 final clear");
        cyc(0, 16'h0000, 0, 0,   0, 16'h0000, 0,   0, 16'h0000, 0, 0, "R1 idle end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule